// File: doc/BRIEF.md
# Programmable Raster Sync and Blank Generator

This block generates the horizontal and vertical timing signals for a raster display from one pixel clock. A horizontal counter runs from 1 to a programmed line length. A vertical counter counts lines per frame, or half lines in interlaced mode. A set of window comparators turns programmed start and end counts into horizontal and vertical blanking, sync, cursor and gating windows and a vertical interrupt window. All counts are 12 bits wide.

A status word selects what each of the four shared output pins carries: separate or composite blank and sync, horizontal or vertical gates, the cursor, or the vertical interrupt. The status word also sets the polarity of each pin and starts or stops the timing clock. An odd/even pin reports the current field.

The status word is written through a single-word port. The timing values arrive as static inputs from the surrounding register file. Outputs are registered on the falling clock edge. The reset value of the clock-run bit is a build-time parameter.

Top module: `vtg_top`

## Requirements
- R1: While `rst_ni` is low, all four pins and `odd_even_o` read 1. Both counters sit at 1, the field flag marks the odd field, and the status word takes its reset value. The status word is written on a rising edge when `stat_we_i` is high.
- R2: While running, the horizontal count advances by one on each rising edge from 1 up to `h_total_i`, then returns to 1.
- R3: A window with start `s` and end `e` is active for counts `c` with `s < c <= e`, so a pulse programmed with width n ends n+1 clocks after count 1. The blank windows use start 0 with ends `h_blank_w_i` and `v_blank_w_i`. The sync windows run from the front-porch value to the sync-end value. The cursor windows use the four cursor registers, and the interrupt window runs from `vint_on_i` to `vint_off_i`.
- R4: In non-interlaced mode (status bits 4:3 not 00), the vertical count advances when the horizontal count is at `h_total_i`, and returns to 1 after `v_total_i`.
- R5: In interlaced mode (status bits 4:3 = 00), the vertical count also advances at horizontal count `h_total_i/2`. Each vertical wrap toggles the field. `odd_even_o` shows 1 for the odd field and 0 for the even field, and is held at 1 in non-interlaced mode.
- R6: Status bit 0 = 1 puts vertical blank on `blank_o` and horizontal blank on `hblank_o`. Bit 0 = 0 puts the OR of both blanks on `blank_o`.
- R7: Status bit 1 = 1 puts vertical sync on `sync_o` and horizontal sync on `hsync_o`. Bit 1 = 0 puts the OR of both syncs on `sync_o`.
- R8: When status bit 0 = 0, `hblank_o` carries the horizontal cursor window if bit 2 = 0, or the AND of the horizontal and vertical cursor windows if bit 2 = 1. When status bit 1 = 0, `hsync_o` carries the vertical cursor window if bit 2 = 0, or the interrupt window if bit 2 = 1.
- R9: Status bits 5, 6, 7 and 8 set the polarity of `blank_o`, `sync_o`, `hblank_o` and `hsync_o`. A 1 drives the active state high and a 0 drives it low.
- R10: Status bit 10 = 0 freezes both counters, the field flag and all pins. Setting it to 1 resumes from the held position.
- R11: Parameter `CLK_ON_AT_CLEAR` sets the reset value of status bit 10. The status word resets to 0x000 when the parameter is 0 and to 0x400 when it is 1.
- R12: The pins change only on a falling clock edge. They show the decode of the counter position and status word as they stand after the preceding rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_we_i | input | 1 | Status word write strobe |
| stat_wdata_i | input | 12 | Status word write data |
| h_total_i | input | 12 | Clocks per line (even) |
| h_fp_i | input | 12 | Horizontal sync start count |
| h_sync_end_i | input | 12 | Horizontal sync end count |
| h_blank_w_i | input | 12 | Horizontal blank width |
| v_total_i | input | 12 | Lines (or half lines) per field/frame |
| v_fp_i | input | 12 | Vertical sync start count |
| v_sync_end_i | input | 12 | Vertical sync end count |
| v_blank_w_i | input | 12 | Vertical blank width |
| cur_h_start_i | input | 12 | Cursor/gate horizontal start |
| cur_h_end_i | input | 12 | Cursor/gate horizontal end |
| cur_v_start_i | input | 12 | Cursor/gate vertical start |
| cur_v_end_i | input | 12 | Cursor/gate vertical end |
| vint_on_i | input | 12 | Vertical interrupt start line |
| vint_off_i | input | 12 | Vertical interrupt end line |
| blank_o | output | 1 | Vertical or composite blank |
| sync_o | output | 1 | Vertical or composite sync |
| hblank_o | output | 1 | Horizontal blank, horizontal gate or cursor |
| hsync_o | output | 1 | Horizontal sync, vertical gate or interrupt |
| odd_even_o | output | 1 | Field indicator |

## Verification
A status write lands on the next rising edge. The counters take their next position on every rising edge. The pins show that position half a cycle later, on the falling edge. The bench therefore keeps its own counter model, stepped on each rising edge from the requirements. It waits until the model reaches a target position and reads the pins 1 ns after the falling edge that follows. For a status write that starts or stops the clock, the capture edge itself does not move the counters, so the first falling edge after the write shows the held position.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // status word bit positions (decoded by the output stage)
  localparam int unsigned STAT_W      = 12;
  localparam int unsigned SB_SEL0     = 0;
  localparam int unsigned SB_SEL1     = 1;
  localparam int unsigned SB_SEL2     = 2;
  localparam int unsigned SB_MODE_LO  = 3;
  localparam int unsigned SB_MODE_HI  = 4;
  localparam int unsigned SB_POL_BLK  = 5;
  localparam int unsigned SB_POL_SYN  = 6;
  localparam int unsigned SB_POL_HBL  = 7;
  localparam int unsigned SB_POL_HSY  = 8;
  localparam int unsigned SB_RUN      = 10;

  typedef enum logic [2:0] {
    W_HBLANK = 3'd0,
    W_HSYNC  = 3'd1,
    W_HCUR   = 3'd2,
    W_VBLANK = 3'd3,
    W_VSYNC  = 3'd4,
    W_VCUR   = 3'd5,
    W_VINT   = 3'd6
  } win_e;

  localparam int unsigned NWIN = 7;

  function automatic logic pin_drive(input logic raw, input logic pol_hi);
    return pol_hi ? raw : ~raw;
  endfunction

  function automatic logic is_interlaced(input logic [1:0] mode);
    return mode == 2'b00;
  endfunction

endpackage

// File: rtl/vtg_window.sv
module vtg_window #(
  parameter int unsigned CNT_W = 12
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] end_i,
  output logic             act_o
);
  // half-open window: edge programmed as n lands n+1 counts after count 1
  assign act_o = (cnt_i > start_i) && (cnt_i <= end_i);
endmodule

// File: rtl/vtg_timebase.sv
module vtg_timebase #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ilace_i,
  input  logic [CNT_W-1:0] h_total_i,
  input  logic [CNT_W-1:0] v_total_i,
  output logic [CNT_W-1:0] hcnt_o,
  output logic [CNT_W-1:0] vcnt_o,
  output logic             field_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] hcnt_q, vcnt_q;
  logic             field_q;
  logic             h_last, h_half, v_step, v_last;

  assign h_last = hcnt_q >= h_total_i;
  assign h_half = ilace_i && (hcnt_q == (h_total_i >> 1));
  assign v_step = h_last || h_half;
  assign v_last = vcnt_q >= v_total_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= ONE;
    end else if (run_i) begin
      hcnt_q <= h_last ? ONE : hcnt_q + ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vcnt_q  <= ONE;
      field_q <= 1'b1;
    end else if (run_i) begin
      if (v_step) begin
        vcnt_q <= v_last ? ONE : vcnt_q + ONE;
      end
      if (!ilace_i) begin
        field_q <= 1'b1;
      end else if (v_step && v_last) begin
        field_q <= ~field_q;
      end
    end
  end

  assign hcnt_o  = hcnt_q;
  assign vcnt_o  = vcnt_q;
  assign field_o = field_q;

  a_r2_hcnt_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q != '0);

  a_r2_hcnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (hcnt_q < h_total_i)) |=> (hcnt_q == $past(hcnt_q) + ONE));

  a_r4_vcnt_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && h_last && (vcnt_q >= v_total_i)) |=> (vcnt_q == ONE));

  a_r5_field_odd_progressive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !ilace_i) |=> field_q);

  a_r10_counters_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(hcnt_q) && $stable(vcnt_q) && $stable(field_q)));

endmodule

// File: rtl/vtg_outmux.sv
module vtg_outmux
  import vtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [NWIN-1:0]   win_i,
  input  logic              field_i,
  output logic              blank_o,
  output logic              sync_o,
  output logic              hblank_o,
  output logic              hsync_o,
  output logic              odd_even_o
);
  logic run, cur_mode;
  logic blank_raw, sync_raw, hbl_raw, hsy_raw;
  logic [4:0] pins_d, pins_q;

  assign run      = stat_i[SB_RUN];
  assign cur_mode = stat_i[SB_SEL2];

  always_comb begin
    blank_raw = stat_i[SB_SEL0] ? win_i[W_VBLANK] : (win_i[W_HBLANK] | win_i[W_VBLANK]);
    sync_raw  = stat_i[SB_SEL1] ? win_i[W_VSYNC]  : (win_i[W_HSYNC]  | win_i[W_VSYNC]);
    if (stat_i[SB_SEL0])  hbl_raw = win_i[W_HBLANK];
    else if (cur_mode)    hbl_raw = win_i[W_HCUR] & win_i[W_VCUR];
    else                  hbl_raw = win_i[W_HCUR];
    if (stat_i[SB_SEL1])  hsy_raw = win_i[W_HSYNC];
    else if (cur_mode)    hsy_raw = win_i[W_VINT];
    else                  hsy_raw = win_i[W_VCUR];
    pins_d = {pin_drive(blank_raw, stat_i[SB_POL_BLK]),
              pin_drive(sync_raw,  stat_i[SB_POL_SYN]),
              pin_drive(hbl_raw,   stat_i[SB_POL_HBL]),
              pin_drive(hsy_raw,   stat_i[SB_POL_HSY]),
              is_interlaced(stat_i[SB_MODE_HI:SB_MODE_LO]) ? field_i : 1'b1};
  end

  // pins launch on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  pins_q <= '1;
    else if (run) pins_q <= pins_d;
  end

  assign {blank_o, sync_o, hblank_o, hsync_o, odd_even_o} = pins_q;

  a_r10_pins_hold: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(pins_q));

  a_r5_progressive_odd: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (run && !is_interlaced(stat_i[SB_MODE_HI:SB_MODE_LO])) |=> odd_even_o);

endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int unsigned CNT_W           = 12,
  parameter bit          CLK_ON_AT_CLEAR = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stat_we_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  input  logic [CNT_W-1:0]  h_total_i,
  input  logic [CNT_W-1:0]  h_fp_i,
  input  logic [CNT_W-1:0]  h_sync_end_i,
  input  logic [CNT_W-1:0]  h_blank_w_i,
  input  logic [CNT_W-1:0]  v_total_i,
  input  logic [CNT_W-1:0]  v_fp_i,
  input  logic [CNT_W-1:0]  v_sync_end_i,
  input  logic [CNT_W-1:0]  v_blank_w_i,
  input  logic [CNT_W-1:0]  cur_h_start_i,
  input  logic [CNT_W-1:0]  cur_h_end_i,
  input  logic [CNT_W-1:0]  cur_v_start_i,
  input  logic [CNT_W-1:0]  cur_v_end_i,
  input  logic [CNT_W-1:0]  vint_on_i,
  input  logic [CNT_W-1:0]  vint_off_i,
  output logic              blank_o,
  output logic              sync_o,
  output logic              hblank_o,
  output logic              hsync_o,
  output logic              odd_even_o
);
  localparam logic [STAT_W-1:0] STAT_RST = STAT_W'(CLK_ON_AT_CLEAR) << SB_RUN;
  // bits 9 and 11 carry features outside this block
  localparam logic [STAT_W-1:0] STAT_MASK = 12'h5FF;

  logic [STAT_W-1:0] stat_q;
  logic              unused_stat;
  logic [CNT_W-1:0]  hcnt, vcnt;
  logic              field;
  logic [CNT_W-1:0]  win_cnt [NWIN];
  logic [CNT_W-1:0]  win_lo  [NWIN];
  logic [CNT_W-1:0]  win_hi  [NWIN];
  logic [NWIN-1:0]   win_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stat_q <= STAT_RST;
    else if (stat_we_i) stat_q <= stat_wdata_i & STAT_MASK;
  end

  assign unused_stat = ^{stat_q[9], stat_q[11]};

  vtg_timebase #(.CNT_W(CNT_W)) i_timebase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (stat_q[SB_RUN]),
    .ilace_i   (is_interlaced(stat_q[SB_MODE_HI:SB_MODE_LO])),
    .h_total_i (h_total_i),
    .v_total_i (v_total_i),
    .hcnt_o    (hcnt),
    .vcnt_o    (vcnt),
    .field_o   (field)
  );

  always_comb begin
    win_cnt[W_HBLANK] = hcnt; win_lo[W_HBLANK] = '0;            win_hi[W_HBLANK] = h_blank_w_i;
    win_cnt[W_HSYNC]  = hcnt; win_lo[W_HSYNC]  = h_fp_i;        win_hi[W_HSYNC]  = h_sync_end_i;
    win_cnt[W_HCUR]   = hcnt; win_lo[W_HCUR]   = cur_h_start_i; win_hi[W_HCUR]   = cur_h_end_i;
    win_cnt[W_VBLANK] = vcnt; win_lo[W_VBLANK] = '0;            win_hi[W_VBLANK] = v_blank_w_i;
    win_cnt[W_VSYNC]  = vcnt; win_lo[W_VSYNC]  = v_fp_i;        win_hi[W_VSYNC]  = v_sync_end_i;
    win_cnt[W_VCUR]   = vcnt; win_lo[W_VCUR]   = cur_v_start_i; win_hi[W_VCUR]   = cur_v_end_i;
    win_cnt[W_VINT]   = vcnt; win_lo[W_VINT]   = vint_on_i;     win_hi[W_VINT]   = vint_off_i;
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    vtg_window #(.CNT_W(CNT_W)) i_win (
      .cnt_i   (win_cnt[g]),
      .start_i (win_lo[g]),
      .end_i   (win_hi[g]),
      .act_o   (win_act[g])
    );
  end

  vtg_outmux i_outmux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stat_i     (stat_q),
    .win_i      (win_act),
    .field_i    (field),
    .blank_o    (blank_o),
    .sync_o     (sync_o),
    .hblank_o   (hblank_o),
    .hsync_o    (hsync_o),
    .odd_even_o (odd_even_o)
  );

  a_r1_stat_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i |=> (stat_q[SB_RUN] == $past(stat_wdata_i[SB_RUN])));

endmodule

// File: tb/test_vtg_top.sv
module test_vtg_top;
  localparam int HT = 10;
  localparam int VT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [11:0] wdata = '0;
  logic b1, s1, hb1, hs1, oe1;
  logic b2, s2, hb2, hs2, oe2;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  vtg_top #(.CLK_ON_AT_CLEAR(1'b0)) i_vtg_top (
    .clk_i(clk), .rst_ni(rst_n), .stat_we_i(we), .stat_wdata_i(wdata),
    .h_total_i(12'(HT)), .h_fp_i(12'd2), .h_sync_end_i(12'd4), .h_blank_w_i(12'd3),
    .v_total_i(12'(VT)), .v_fp_i(12'd1), .v_sync_end_i(12'd2), .v_blank_w_i(12'd2),
    .cur_h_start_i(12'd5), .cur_h_end_i(12'd7), .cur_v_start_i(12'd3), .cur_v_end_i(12'd5),
    .vint_on_i(12'd5), .vint_off_i(12'd6),
    .blank_o(b1), .sync_o(s1), .hblank_o(hb1), .hsync_o(hs1), .odd_even_o(oe1));

  vtg_top #(.CLK_ON_AT_CLEAR(1'b1)) i_vtg_top_run (
    .clk_i(clk), .rst_ni(rst_n), .stat_we_i(1'b0), .stat_wdata_i(12'h000),
    .h_total_i(12'(HT)), .h_fp_i(12'd2), .h_sync_end_i(12'd4), .h_blank_w_i(12'd3),
    .v_total_i(12'(VT)), .v_fp_i(12'd1), .v_sync_end_i(12'd2), .v_blank_w_i(12'd2),
    .cur_h_start_i(12'd5), .cur_h_end_i(12'd7), .cur_v_start_i(12'd3), .cur_v_end_i(12'd5),
    .vint_on_i(12'd5), .vint_off_i(12'd6),
    .blank_o(b2), .sync_o(s2), .hblank_o(hb2), .hsync_o(hs2), .odd_even_o(oe2));

  // reference position model, stepped from R2/R4/R5/R10
  int m_h, m_v;
  logic m_f;
  logic [11:0] m_stat;
  logic m_il, m_step;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 1; m_v = 1; m_f = 1'b1; m_stat = 12'h000;
    end else begin
      if (m_stat[10]) begin
        m_il = (m_stat[4:3] == 2'b00);
        m_step = (m_h == HT) || (m_il && m_h == HT / 2);
        if (m_step) begin
          if (m_v >= VT) begin
            m_v = 1;
            if (m_il) m_f = ~m_f;
          end else m_v = m_v + 1;
        end
        if (!m_il) m_f = 1'b1;
        m_h = (m_h >= HT) ? 1 : m_h + 1;
      end
      if (we) m_stat = wdata;
    end
  end

  // stimulus table: status, h, v, expected {blank,sync,hblank,hsync}
  typedef struct packed {
    logic [11:0] st;
    logic [7:0]  h;
    logic [7:0]  v;
    logic [3:0]  exp;
  } vec_t;
  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{12'h5F8, 8'd2, 8'd4, 4'b1001},  // R6 R7 R8 composite, gates
    '{12'h5F8, 8'd6, 8'd2, 4'b1110},  // R6 R7 R8 R3
    '{12'h5FB, 8'd3, 8'd4, 4'b0011},  // R6 R7 separate
    '{12'h5FC, 8'd6, 8'd5, 4'b0010},  // R8 cursor
    '{12'h5FC, 8'd7, 8'd6, 4'b0001},  // R8 vint
    '{12'h5FC, 8'd4, 8'd1, 4'b1100},  // R3 blank ends after width
    '{12'h41B, 8'd3, 8'd2, 4'b0000},  // R9 active low
    '{12'h41B, 8'd8, 8'd7, 4'b1111},  // R9 idle high
    '{12'h53B, 8'd1, 8'd1, 4'b1100}   // R9 mixed, R2 count 1
  };

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, got, exp);
    end
  endtask

  task automatic wr_stat(input logic [11:0] v);
    we = 1'b1; wdata = v;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic wait_pos(input int h, input int v);
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      if (m_h == h && m_v == v) break;
    end
    @(negedge clk); #1;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #13;
    check("R1 reset pins", {b1, s1, hb1, hs1, oe1}, 5'b11111);
    check("R1 reset pins run variant", {b2, s2, hb2, hs2, oe2}, 5'b11111);
    #9 rst_n = 1'b1;
    // five rising edges: run variant reaches h=6 (cursor gate, active low)
    repeat (5) @(posedge clk);
    @(negedge clk); #1;
    check("R11 run-at-clear variant advances", {2'b00, hb2, 2'b00}, 5'b00000);
    check("R11 R10 stopped variant holds", {b1, s1, hb1, hs1, oe1}, 5'b11111);

    // start: capture edge does not step, first fall shows (1,1)
    wr_stat(12'h5FB);
    @(negedge clk); #1;
    check("R10 R12 start at (1,1)", {b1, s1, hb1, hs1, oe1}, 5'b10101);

    for (int i = 0; i < NVEC; i++) begin
      if (m_stat != VECS[i].st) wr_stat(VECS[i].st);
      wait_pos(int'(VECS[i].h), int'(VECS[i].v));
      check($sformatf("R3 R6 R7 R8 R9 R5 vector %0d", i),
            {b1, s1, hb1, hs1, oe1}, {VECS[i].exp, 1'b1});
    end

    // stop at (2,4) decode; counter parks at (3,4)
    wr_stat(12'h5FB);
    wait_pos(2, 4);
    wr_stat(12'h1FB);
    repeat (20) @(posedge clk);
    @(negedge clk); #1;
    check("R10 pins frozen", {b1, s1, hb1, hs1, oe1}, 5'b00101);
    wr_stat(12'h5FB);
    @(negedge clk); #1;
    check("R10 resume from held (3,4)", {b1, s1, hb1, hs1, oe1}, 5'b00111);

    // interlaced field
    rst_n = 1'b0; #20; rst_n = 1'b1; #1;
    wr_stat(12'h5E3);
    wait_pos(8, 2);
    check("R5 odd field half-line step", {b1, s1, hb1, hs1, oe1}, 5'b11001);
    wait_pos(3, 3);
    check("R5 half-line vertical count", {b1, s1, hb1, hs1, oe1}, 5'b00111);
    wait_pos(8, 2);
    check("R5 even field after wrap", {b1, s1, hb1, hs1, oe1}, 5'b11000);
    wr_stat(12'h5FB);
    wait_pos(8, 5);
    check("R5 progressive forces odd", {b1, s1, hb1, hs1, oe1}, 5'b00001);

    finish_run();
  end
endmodule